// File: doc/BRIEF.md
# Drive Status and Media-Change Indicator

This block is the status logic on the drive side of a removable-media drive. It tracks two conditions. The first is a latched media-changed flag. Power-on sets it, and so does the loss of the media-present switch. It clears only when media is in place and the host issues a step pulse while it selects the drive. The second is a ready level. Ready asserts once the media has been clamped, the motor request has been held for the spin-up delay, and an index pulse has been seen since the motor was requested.

Both conditions leave the block on one shared open-drain status pin. A strap input chooses which of the two drives that pin. A free-running prescaler turns the system clock into 1 µs ticks, and the clamp and spin-up timers count those ticks. The media switch and the index sense pass through two-stage synchronizers before use. All pins are low-true. A drive that is not selected leaves the status pin released (high).

Top module: `drive_status`

## Requirements
- R1: After reset the media-changed flag is set. With the drive selected and `strap_rdy` = 0, `stat_pin_n` is low.
- R2: When `media_in_n` goes high (no media), the flag is set within three clock cycles and stays set while media is absent.
- R3: The flag clears only on a rising edge of `step_n` sampled while `sel_n` is low and the synchronized media switch shows media present. A step while deselected, or while media is absent, leaves the flag set.
- R4: The prescaler produces one tick every `CLKS_PER_US` clocks starting at reset. The clamp and spin-up timers advance only on ticks, so ready follows the cycle-exact tick timing.
- R5: Ready is high only when three conditions all hold: media has been present for `CLAMP_US` ticks, `motor_n` has been low with media present for `READY_US` ticks, and a falling edge of the synchronized index has occurred since then.
- R6: Ready is low from the first clock edge at which `motor_n` is sampled high.
- R7: Media removal drops ready and restarts the clamp timer, the spin-up timer and the index detection.
- R8: With `strap_rdy` = 1 the status pin shows ready (low = ready). With `strap_rdy` = 0 it shows the changed flag (low = changed).
- R9: While `sel_n` is high, `stat_pin_n` is high. When `sel_n` goes low, the pin shows the selected status in the same cycle, with no register in the path.
- R10: Index falling edges that occur while the motor is off do not count towards ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous power-on reset, low-true |
| media_in_n | input | 1 | Media-present switch, low = media installed (asynchronous) |
| motor_n | input | 1 | Motor-on request, low-true |
| sel_n | input | 1 | Drive select, low-true |
| step_n | input | 1 | Step strobe, low pulse; its rising edge is the event |
| index_n | input | 1 | Per-revolution index sense, low pulse (asynchronous) |
| strap_rdy | input | 1 | Strap: 1 = ready on the pin, 0 = changed flag on the pin |
| stat_pin_n | output | 1 | Shared open-drain status pin, low = asserted, high = released |

## Verification
The bench builds the block with `CLKS_PER_US` = 4, `CLAMP_US` = 6 and `READY_US` = 20. With these values a full clamp and spin-up sequence completes in about a hundred cycles, so the bench can repeat it several times. It covers a restart after motor-off and a restart after media removal, and it compares the ready timing against the tick grid on every cycle. The small prescaler value also puts the tick boundaries close enough together to expose an off-by-one in the tick or timer terminal counts.

// File: rtl/drive_status_pkg.sv
// Shared types and helpers for the drive status block.
// Assumes: used only at elaboration time; holds no state.
package drive_status_pkg;

    // Source selected onto the shared status pin by the strap input
    typedef enum logic {
        PIN_SHOWS_CHANGE = 1'b0,
        PIN_SHOWS_READY  = 1'b1
    } pin_src_e;

    // Bits needed to hold the values 0..max_val (never less than one)
    function automatic int cnt_bits(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/dsx_sync.sv
// Two-stage synchronizer for a bundle of asynchronous level inputs.
// Assumes: each bit is independent; no bus coherency is implied.
module dsx_sync #(
    parameter int               WIDTH    = 2,
    parameter logic [WIDTH-1:0] RST_VAL  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_a;
    logic [WIDTH-1:0] stage_b;

    // Capture then retime every bit through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_a <= RST_VAL;
            stage_b <= RST_VAL;
        end else begin
            stage_a <= async_in;
            stage_b <= stage_a;
        end
    end

    assign sync_out = stage_b;

endmodule

// File: rtl/dsx_tick.sv
// Microsecond tick prescaler: pulses tick for one clock every CLKS_PER_US clocks.
// Assumes: CLKS_PER_US >= 1; the first tick comes CLKS_PER_US clocks after reset.
module dsx_tick #(
    parameter int CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    import drive_status_pkg::*;

    localparam int LAST = CLKS_PER_US - 1;
    localparam int CW   = cnt_bits(LAST);

    generate
        if (CLKS_PER_US <= 1) begin : g_passthru
            // Clock already runs at one microsecond per cycle
            assign tick = 1'b1;
        end else begin : g_count
            logic [CW-1:0] div_cnt;

            // Wrap the divider at the terminal count
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_cnt <= '0;
                end else if (div_cnt == CW'(LAST)) begin
                    div_cnt <= '0;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end

            assign tick = (div_cnt == CW'(LAST));
        end
    endgenerate

endmodule

// File: rtl/dsx_chg_flag.sv
// Media-changed latch: set by reset or absent media, cleared by a selected step.
// Assumes: media_ok is already synchronized; step_n and sel_n are slow host
// levels held stable across several clocks, so one edge register is enough.
module dsx_chg_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic media_ok,
    input  logic step_n,
    input  logic sel_n,
    output logic step_evt,
    output logic chg
);

    logic step_prev;

    // Remember the last sampled step level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_prev <= 1'b1;
        end else begin
            step_prev <= step_n;
        end
    end

    // Trailing edge of the low step pulse while the drive is selected
    assign step_evt = step_n & ~step_prev & ~sel_n;

    // Absent media dominates; a selected step with media clears the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg <= 1'b1;
        end else if (!media_ok) begin
            chg <= 1'b1;
        end else if (step_evt) begin
            chg <= 1'b0;
        end
    end

endmodule

// File: rtl/dsx_ready.sv
// Ready qualification: clamp timer, spin-up timer and index-seen latch.
// Assumes: media_ok and idx_s are synchronized; tick is a one-cycle pulse;
// the timers saturate at their limits and restart on motor-off or media loss.
module dsx_ready #(
    parameter int CLAMP_US = 250_000,
    parameter int READY_US = 505_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic media_ok,
    input  logic motor_on,
    input  logic idx_s,
    output logic ready
);

    import drive_status_pkg::*;

    localparam int CLW = cnt_bits(CLAMP_US);
    localparam int RDW = cnt_bits(READY_US);

    logic [CLW-1:0] clamp_cnt;
    logic [RDW-1:0] spin_cnt;
    logic           idx_prev;
    logic           idx_fall;
    logic           idx_seen;
    logic           clamp_done;
    logic           spin_done;
    logic           run_ok;

    assign run_ok     = media_ok & motor_on;
    assign idx_fall   = idx_prev & ~idx_s;
    assign clamp_done = (clamp_cnt == CLW'(CLAMP_US));
    assign spin_done  = (spin_cnt == RDW'(READY_US));

    // Clamp settle time counted from media detection
    always_ff @(posedge clk) begin
        if (!rst_n || !media_ok) begin
            clamp_cnt <= '0;
        end else if (tick && !clamp_done) begin
            clamp_cnt <= clamp_cnt + 1'b1;
        end
    end

    // Spin-up delay counted while the motor request holds with media present
    always_ff @(posedge clk) begin
        if (!rst_n || !run_ok) begin
            spin_cnt <= '0;
        end else if (tick && !spin_done) begin
            spin_cnt <= spin_cnt + 1'b1;
        end
    end

    // Previous index level for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_prev <= 1'b1;
        end else begin
            idx_prev <= idx_s;
        end
    end

    // Latch that one revolution mark has passed since the motor request
    always_ff @(posedge clk) begin
        if (!rst_n || !run_ok) begin
            idx_seen <= 1'b0;
        end else if (idx_fall) begin
            idx_seen <= 1'b1;
        end
    end

    assign ready = clamp_done & spin_done & idx_seen;

endmodule

// File: rtl/drive_status.sv
// Drive status top: synchronizes media and index, runs the prescaler, the
// changed-flag latch and ready qualification, and muxes one onto the shared pin.
// Assumes: all pins low-true; pin is open-drain, so 1 means released.
module drive_status #(
    parameter int CLKS_PER_US = 100,
    parameter int CLAMP_US    = 250_000,
    parameter int READY_US    = 505_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic media_in_n,
    input  logic motor_n,
    input  logic sel_n,
    input  logic step_n,
    input  logic index_n,
    input  logic strap_rdy,
    output logic stat_pin_n
);

    import drive_status_pkg::*;

    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    logic              media_ok;
    logic              idx_s;
    logic              tick;
    logic              step_evt;
    logic              chg;
    logic              ready;
    logic              shown;
    pin_src_e          pin_src;

    assign raw_bus  = {index_n, media_in_n};

    dsx_sync #(
        .WIDTH   (SYNC_W),
        .RST_VAL (2'b11)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_bus),
        .sync_out (sync_bus)
    );

    assign media_ok = ~sync_bus[0];
    assign idx_s    = sync_bus[1];

    dsx_tick #(
        .CLKS_PER_US (CLKS_PER_US)
    ) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dsx_chg_flag chg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .media_ok (media_ok),
        .step_n   (step_n),
        .sel_n    (sel_n),
        .step_evt (step_evt),
        .chg      (chg)
    );

    dsx_ready #(
        .CLAMP_US (CLAMP_US),
        .READY_US (READY_US)
    ) rdy_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .media_ok (media_ok),
        .motor_on (~motor_n),
        .idx_s    (idx_s),
        .ready    (ready)
    );

    assign pin_src = pin_src_e'(strap_rdy);

    // Pick the strapped status and gate it with select onto the open-drain pin
    always_comb begin
        shown      = (pin_src == PIN_SHOWS_READY) ? ready : chg;
        stat_pin_n = sel_n ? 1'b1 : ~shown;
    end

endmodule

// File: rtl/drive_status_chk.sv
// Property checker for drive_status, attached with bind below.
// Assumes: sampled on the system clock, disabled during reset.
module drive_status_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_n,
    input logic motor_n,
    input logic stat_pin_n,
    input logic media_ok,
    input logic step_evt,
    input logic chg,
    input logic ready
);

    // R9
    unsel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> stat_pin_n);

    // R2
    absent_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !media_ok |=> chg);

    // R3
    clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chg) |-> ($past(step_evt) && $past(media_ok)));

    // R6
    motor_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        motor_n |=> !ready);

    // R5
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (!$past(motor_n) && $past(media_ok)));

endmodule

bind drive_status drive_status_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .motor_n    (motor_n),
    .stat_pin_n (stat_pin_n),
    .media_ok   (media_ok),
    .step_evt   (step_evt),
    .chg        (chg),
    .ready      (ready)
);

// File: tb/drive_status_tb_top.sv
`timescale 1ns/1ps
module drive_status_tb_top;

    localparam int CPU = 4;
    localparam int CL  = 6;
    localparam int RD  = 20;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic media_in_n = 1'b1;
    logic motor_n = 1'b1;
    logic sel_n = 1'b0;
    logic step_n = 1'b1;
    logic index_n = 1'b1;
    logic strap_rdy = 1'b0;
    logic stat_pin_n;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    drive_status #(
        .CLKS_PER_US (CPU),
        .CLAMP_US    (CL),
        .READY_US    (RD)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .media_in_n (media_in_n),
        .motor_n    (motor_n),
        .sel_n      (sel_n),
        .step_n     (step_n),
        .index_n    (index_n),
        .strap_rdy  (strap_rdy),
        .stat_pin_n (stat_pin_n)
    );

    // Behavioural reference: queues for the input delays, integers for timers
    bit m_media_q[$];
    bit m_index_q[$];
    int m_div, m_clamp, m_spin;
    bit m_chg, m_seen, m_idx_last, m_step_last;

    function automatic bit m_ready();
        return (m_clamp == CL) && (m_spin == RD) && m_seen;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_media_q = '{1'b1, 1'b1};
            m_index_q = '{1'b1, 1'b1};
            m_div = 0; m_clamp = 0; m_spin = 0;
            m_chg = 1; m_seen = 0; m_idx_last = 1; m_step_last = 1;
        end else begin
            bit present, idx, run, tk, stp;
            present = !m_media_q[0];
            idx     = m_index_q[0];
            run     = present && !motor_n;
            tk      = (m_div == CPU - 1);
            stp     = step_n && !m_step_last && !sel_n;
            m_div   = tk ? 0 : m_div + 1;
            if (!present) m_chg = 1; else if (stp) m_chg = 0;
            if (!present) m_clamp = 0; else if (tk && m_clamp < CL) m_clamp++;
            if (!run) m_spin = 0; else if (tk && m_spin < RD) m_spin++;
            if (!run) m_seen = 0; else if (m_idx_last && !idx) m_seen = 1;
            m_idx_last  = idx;
            m_step_last = step_n;
            void'(m_media_q.pop_front());
            void'(m_index_q.pop_front());
            m_media_q.push_back(media_in_n);
            m_index_q.push_back(index_n);
        end
    end

    // Compare the pin with the reference on every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp;
            exp = sel_n ? 1'b1 : ~(strap_rdy ? m_ready() : m_chg);
            checks++;
            if (stat_pin_n !== exp) begin
                fails++;
                $display("FAIL %s cycle %0d: pin=%b expected=%b",
                         sel_n ? "R9" : (strap_rdy ? "R4" : "R2"), cyc, stat_pin_n, exp);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            checks++; fails++;
            $display("FAIL watchdog: cycle=%0d expected=finish", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit exp, input string tag);
        @(negedge clk);
        checks++;
        if (stat_pin_n !== exp) begin
            fails++;
            $display("FAIL %s: pin=%b expected=%b", tag, stat_pin_n, exp);
        end
    endtask

    task automatic pulse_step();
        step_n = 1'b0; wait_cyc(2);
        step_n = 1'b1; wait_cyc(1);
    endtask

    task automatic pulse_index();
        index_n = 1'b0; wait_cyc(3);
        index_n = 1'b1; wait_cyc(1);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        check(1'b0, "R1 flag set after reset");
        strap_rdy = 1'b1; wait_cyc(1);
        check(1'b1, "R8 ready shown, not ready");
        strap_rdy = 1'b0; sel_n = 1'b1; wait_cyc(1);
        check(1'b1, "R9 deselected released");
        media_in_n = 1'b0; wait_cyc(5);
        pulse_step();
        sel_n = 1'b0; wait_cyc(1);
        check(1'b0, "R3 deselected step ignored");
        pulse_step(); wait_cyc(1);
        check(1'b1, "R3 selected step clears");
        pulse_index();
        motor_n = 1'b0; wait_cyc(120);
        strap_rdy = 1'b1; wait_cyc(1);
        check(1'b1, "R10 index before motor ignored");
        pulse_index(); wait_cyc(3);
        check(1'b0, "R5 ready after index");
        strap_rdy = 1'b0; wait_cyc(1);
        check(1'b1, "R8 flag shown, clear");
        strap_rdy = 1'b1;
        motor_n = 1'b1; wait_cyc(1);
        check(1'b1, "R6 motor off drops ready");
        motor_n = 1'b0; pulse_index(); wait_cyc(40);
        check(1'b1, "R5 spin-up not elapsed");
        wait_cyc(60);
        check(1'b0, "R5 ready after spin-up");
        media_in_n = 1'b1; wait_cyc(3);
        check(1'b1, "R7 removal drops ready");
        strap_rdy = 1'b0; wait_cyc(1);
        check(1'b0, "R2 removal sets flag");
        pulse_step(); wait_cyc(1);
        check(1'b0, "R3 step with no media ignored");
        media_in_n = 1'b0; strap_rdy = 1'b1; wait_cyc(6);
        check(1'b1, "R7 timers restarted");
        pulse_index(); wait_cyc(100);
        check(1'b0, "R4 ready again on tick grid");
        wait_cyc(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule